// File: doc/BRIEF.md
# Ethernet Transceiver Basic Control and Status Registers

This block is the management-side register file for a tri-speed Ethernet transceiver. It holds the basic control word at address 0 and the basic status word at address 1. A management agent, such as an MDIO frame decoder, reaches both words through a plain one-cycle access strobe. At hardware reset it samples four strap inputs, which give the power-on speed, duplex and auto-negotiation setting.

Speed, duplex and auto-negotiation enable are written into a pending copy. The copy is only pushed to the effective link outputs on one of three trigger events:
- a software reset request,
- a negotiation restart request,
- a release from power-down.

Each trigger also emits one-cycle strobes that the negotiation engine and the datapath consume. A collision-test mode echoes the transmit-enable input onto a collision output, paced by a bit-time tick.

The access port carries no stream of data, so it stays a plain strobe without back-pressure. Every access is accepted in the cycle it is presented. Read data returns exactly one cycle later with a valid flag.

Top module: `phy_mgmt_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, the effective and pending link settings load from `strap_in`. Bits [1:0] give the speed code (00 = 10 Mb/s, 01 = 100 Mb/s, 10 = 1000 Mb/s), bit 2 gives duplex (1 = full) and bit 3 gives auto-negotiation enable. Power-down and collision test clear.
- R2: A control write (address 0) stores speed {bit 6, bit 13}, auto-negotiation enable (bit 12) and duplex (bit 8) as pending values. These values read back at once, but the effective outputs do not change unless the same write is a trigger.
- R3: A control write is a trigger when any of the following holds: bit 15 (software reset) is 1, bit 9 (restart negotiation) is 1, or bit 11 is 0 while power-down is currently set. On a trigger, the written speed, duplex and enable show on the effective outputs in the cycle after the write.
- R4: Leaving power-down raises both `soft_reset_pulse` and `aneg_restart_pulse` for one cycle, even with bits 15 and 9 written as 0.
- R5: `aneg_restart_pulse` is high for the one cycle after every trigger write and for the first cycle after `rst_n` rises. `soft_reset_pulse` is high for the one cycle after a write with bit 15 set.
- R6: Control bits 15 and 9 are self-clearing and always read 0. The unused control bits 14, 10 and 5:0 read 0.
- R7: When the effective speed code is 10 (1000 Mb/s), `eff_aneg_en` is 1 whatever value was written or strapped.
- R8: The status word reads 16'h7800: bits 14..11 are 1 and all other bits are 0. Writes to address 1 change nothing.
- R9: A read of any address other than 0 or 1 returns zero.
- R10: On every cycle with `bit_tick` high, `col_out` takes (`txen` AND collision test). Collision test is control bit 7, and the tick value uses the setting held before that edge. `col_out` holds between ticks, so it follows `txen` one tick late.
- R11: `power_down` shows the last written control bit 11 in the cycle after the write.
- R12: A read request (`acc_en` high, `acc_write` low) gives `rd_valid` high and `rd_data` in the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| strap_in | input | 4 | Strap values sampled during reset |
| acc_en | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | Register address |
| acc_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| bit_tick | input | 1 | One pulse per bit time |
| txen | input | 1 | Transmit enable from the MAC side |
| col_out | output | 1 | Collision indication |
| eff_speed | output | 2 | Effective speed code |
| eff_duplex | output | 1 | Effective duplex |
| eff_aneg_en | output | 1 | Effective auto-negotiation enable |
| power_down | output | 1 | Power-down request |
| soft_reset_pulse | output | 1 | One-cycle software reset strobe |
| aneg_restart_pulse | output | 1 | One-cycle negotiation restart strobe |

## Verification
The timing of each result is as follows:
- Effective settings, both strobes and `power_down` change in the cycle right after the accepted write edge.
- Read data is due one cycle after the request.
- `col_out` moves one cycle after a tick edge.

The bench drives inputs on the falling edge and steps a behavioural model on the rising edge. It compares every output on the next falling edge, so each result is checked in the exact cycle it is due and a pulse is never missed. Directed checks sample at the same point right after each access task returns.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 5;

  // control word bit positions (decoded by the management host)
  localparam int unsigned C_SRST    = 15;
  localparam int unsigned C_SPD_LSB = 13;
  localparam int unsigned C_ANEG    = 12;
  localparam int unsigned C_PDOWN   = 11;
  localparam int unsigned C_RESTART = 9;
  localparam int unsigned C_DUPLEX  = 8;
  localparam int unsigned C_COLTEST = 7;
  localparam int unsigned C_SPD_MSB = 6;

  localparam logic [ADDR_W-1:0] A_CTRL = 5'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 5'd1;

  localparam logic [1:0] SPD_10   = 2'b00;
  localparam logic [1:0] SPD_100  = 2'b01;
  localparam logic [1:0] SPD_1000 = 2'b10;

  typedef struct packed {
    logic [1:0] speed;
    logic       duplex;
    logic       aneg;
  } link_cfg_t;

  function automatic link_cfg_t strap_to_cfg(input logic [3:0] s);
    link_cfg_t c;
    c.speed  = s[1:0];
    c.duplex = s[2];
    c.aneg   = s[3];
    return c;
  endfunction

  function automatic link_cfg_t force_gig_aneg(input link_cfg_t c);
    link_cfg_t r;
    r = c;
    if (c.speed == SPD_1000) r.aneg = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        strap_in,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output link_cfg_t         pend_o,
  output link_cfg_t         eff_o,
  output logic              pd_o,
  output logic              coltest_o,
  output logic              soft_rst_o,
  output logic              restart_o
);
  link_cfg_t pend_q, eff_q, wcfg;
  logic pd_q, ct_q, sr_q, rs_q, hw_kick_q;
  logic leave_pd, trig;

  always_comb begin
    wcfg.speed  = {wr_data[C_SPD_MSB], wr_data[C_SPD_LSB]};
    wcfg.duplex = wr_data[C_DUPLEX];
    wcfg.aneg   = wr_data[C_ANEG];
    leave_pd    = pd_q & ~wr_data[C_PDOWN];
    trig        = wr_en & (wr_data[C_SRST] | wr_data[C_RESTART] | leave_pd);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= strap_to_cfg(strap_in);
      eff_q     <= force_gig_aneg(strap_to_cfg(strap_in));
      pd_q      <= 1'b0;
      ct_q      <= 1'b0;
      sr_q      <= 1'b0;
      rs_q      <= 1'b0;
      hw_kick_q <= 1'b1;
    end else begin
      hw_kick_q <= 1'b0;
      rs_q      <= hw_kick_q | trig;
      sr_q      <= wr_en & (wr_data[C_SRST] | leave_pd);
      if (wr_en) begin
        pend_q <= wcfg;
        pd_q   <= wr_data[C_PDOWN];
        ct_q   <= wr_data[C_COLTEST];
        if (trig) eff_q <= force_gig_aneg(wcfg);
      end
    end
  end

  assign pend_o     = pend_q;
  assign eff_o      = eff_q;
  assign pd_o       = pd_q;
  assign coltest_o  = ct_q;
  assign soft_rst_o = sr_q;
  assign restart_o  = rs_q;
endmodule

// File: rtl/phy_read_mux.sv
module phy_read_mux
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned DATA_W   = REG_W,
  parameter int unsigned AW       = ADDR_W,
  parameter logic [3:0]  CAP_BITS = 4'b1111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  input  link_cfg_t         pend,
  input  logic              pd,
  input  logic              coltest,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] ctrl_word, stat_word, sel_word;

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[C_SPD_LSB] = pend.speed[0];
    ctrl_word[C_SPD_MSB] = pend.speed[1];
    ctrl_word[C_ANEG]    = pend.aneg;
    ctrl_word[C_DUPLEX]  = pend.duplex;
    ctrl_word[C_PDOWN]   = pd;
    ctrl_word[C_COLTEST] = coltest;

    stat_word        = '0;
    stat_word[14:11] = CAP_BITS;

    if (rd_addr == AW'(A_CTRL))      sel_word = ctrl_word;
    else if (rd_addr == AW'(A_STAT)) sel_word = stat_word;
    else                             sel_word = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? sel_word : '0;
    end
  end
endmodule

// File: rtl/phy_col_gen.sv
module phy_col_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic txen,
  input  logic enable,
  output logic col
);
  always_ff @(posedge clk) begin
    if (!rst_n)    col <= 1'b0;
    else if (tick) col <= txen & enable;
  end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W,
  parameter int unsigned AW     = ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        strap_in,
  input  logic              acc_en,
  input  logic              acc_write,
  input  logic [AW-1:0]     acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              bit_tick,
  input  logic              txen,
  output logic              col_out,
  output logic [1:0]        eff_speed,
  output logic              eff_duplex,
  output logic              eff_aneg_en,
  output logic              power_down,
  output logic              soft_reset_pulse,
  output logic              aneg_restart_pulse
);
  link_cfg_t pend, eff;
  logic      coltest, ctrl_wr, rd_en;

  assign ctrl_wr = acc_en & acc_write & (acc_addr == AW'(A_CTRL));
  assign rd_en   = acc_en & ~acc_write;

  phy_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_in  (strap_in),
    .wr_en     (ctrl_wr),
    .wr_data   (acc_wdata),
    .pend_o    (pend),
    .eff_o     (eff),
    .pd_o      (power_down),
    .coltest_o (coltest),
    .soft_rst_o(soft_reset_pulse),
    .restart_o (aneg_restart_pulse)
  );

  phy_read_mux #(.DATA_W(DATA_W), .AW(AW)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (acc_addr),
    .pend    (pend),
    .pd      (power_down),
    .coltest (coltest),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

  phy_col_gen u_col (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (bit_tick),
    .txen  (txen),
    .enable(coltest),
    .col   (col_out)
  );

  assign eff_speed   = eff.speed;
  assign eff_duplex  = eff.duplex;
  assign eff_aneg_en = eff.aneg;
endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_en,
  input logic        acc_write,
  input logic [4:0]  acc_addr,
  input logic        rd_valid,
  input logic [15:0] rd_data,
  input logic        bit_tick,
  input logic        txen,
  input logic        col_out,
  input logic [1:0]  eff_speed,
  input logic        eff_aneg_en,
  input logic        soft_reset_pulse,
  input logic        aneg_restart_pulse
);
  // R3: effective settings move only together with a restart strobe
  assert_eff_only_on_trigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(eff_speed) |-> aneg_restart_pulse);

  // R5: a software reset always comes with a negotiation restart
  assert_reset_implies_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset_pulse |-> aneg_restart_pulse);

  // R7: gigabit speed forces negotiation on
  assert_gig_forces_aneg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_speed == 2'b10) |-> eff_aneg_en);

  // R8: status word constant
  assert_status_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(acc_addr) == 5'd1) |-> (rd_data == 16'h7800));

  // R6: self-clearing and unused control bits read zero
  assert_ctrl_zero_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(acc_addr) == 5'd0) |-> ((rd_data & 16'hC63F) == 16'h0));

  // R12: read data valid follows a read request by one cycle
  assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_write) |=> rd_valid);

  // R10: collision only rises at a tick with txen high
  assert_col_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_out) |-> ($past(bit_tick) && $past(txen)));
endmodule

bind phy_mgmt_regs phy_mgmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_write(acc_write),
  .acc_addr(acc_addr), .rd_valid(rd_valid), .rd_data(rd_data),
  .bit_tick(bit_tick), .txen(txen), .col_out(col_out),
  .eff_speed(eff_speed), .eff_aneg_en(eff_aneg_en),
  .soft_reset_pulse(soft_reset_pulse), .aneg_restart_pulse(aneg_restart_pulse)
);

// File: tb/sim_phy_mgmt_regs.sv
`timescale 1ns/1ps
module sim_phy_mgmt_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] strap_in = 4'b0101;
  logic acc_en = 0, acc_write = 0, bit_tick = 0, txen = 0;
  logic [4:0] acc_addr = 0;
  logic [15:0] acc_wdata = 0;
  logic rd_valid, col_out, eff_duplex, eff_aneg_en, power_down, soft_reset_pulse, aneg_restart_pulse;
  logic [15:0] rd_data;
  logic [1:0] eff_speed;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  phy_mgmt_regs u0 (.*);

  // behavioural reference model
  int m_spd, m_dup, m_an, p_spd, p_dup, p_an, m_pd, m_ct, m_sr, m_rs, m_kick, m_col, m_rv, m_rd;
  always @(posedge clk) begin
    if (!rst_n) begin
      p_spd = strap_in[1:0]; p_dup = strap_in[2]; p_an = strap_in[3];
      m_spd = p_spd; m_dup = p_dup; m_an = (p_spd == 2) ? 1 : p_an;
      m_pd = 0; m_ct = 0; m_sr = 0; m_rs = 0; m_kick = 1; m_col = 0; m_rv = 0; m_rd = 0;
    end else begin
      int leave, trig;
      m_rs = m_kick; m_kick = 0; m_sr = 0; m_rv = 0; m_rd = 0;
      if (bit_tick) m_col = (txen && m_ct) ? 1 : 0;
      if (acc_en && !acc_write) begin
        m_rv = 1;
        if (acc_addr == 0)
          m_rd = ((p_spd % 2) << 13) | (p_an << 12) | (m_pd << 11) | (p_dup << 8) | (m_ct << 7) | ((p_spd / 2) << 6);
        else if (acc_addr == 1) m_rd = 'h7800;
      end
      if (acc_en && acc_write && acc_addr == 0) begin
        leave = (m_pd == 1 && !acc_wdata[11]) ? 1 : 0;
        trig  = (acc_wdata[15] || acc_wdata[9] || leave) ? 1 : 0;
        p_spd = acc_wdata[6] * 2 + acc_wdata[13]; p_dup = acc_wdata[8]; p_an = acc_wdata[12];
        m_pd = acc_wdata[11]; m_ct = acc_wdata[7];
        if (trig) begin
          m_spd = p_spd; m_dup = p_dup; m_an = (p_spd == 2) ? 1 : p_an;
          m_rs = 1; m_sr = (acc_wdata[15] || leave) ? 1 : 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // cycle compare against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk(eff_speed == m_spd, "R3", "eff_speed", eff_speed, m_spd);
    chk(eff_duplex == m_dup, "R3", "eff_duplex", eff_duplex, m_dup);
    chk(eff_aneg_en == m_an, "R7", "eff_aneg_en", eff_aneg_en, m_an);
    chk(power_down == m_pd, "R11", "power_down", power_down, m_pd);
    chk(soft_reset_pulse == m_sr, "R5", "soft_reset_pulse", soft_reset_pulse, m_sr);
    chk(aneg_restart_pulse == m_rs, "R5", "aneg_restart_pulse", aneg_restart_pulse, m_rs);
    chk(col_out == m_col, "R10", "col_out", col_out, m_col);
    chk(rd_valid == m_rv, "R12", "rd_valid", rd_valid, m_rv);
    if (m_rv) chk(rd_data == m_rd, "R12", "rd_data", rd_data, m_rd);
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); acc_en = 1; acc_write = 1; acc_addr = a[4:0]; acc_wdata = d[15:0];
    @(negedge clk); acc_en = 0; acc_write = 0;
  endtask
  task automatic rd(input int a);
    @(negedge clk); acc_en = 1; acc_write = 0; acc_addr = a[4:0];
    @(negedge clk); acc_en = 0;
  endtask
  task automatic tick;
    @(negedge clk); bit_tick = 1;
    @(negedge clk); bit_tick = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(eff_speed == 2'b01 && eff_duplex && !eff_aneg_en, "R1", "strap load", {eff_speed, eff_duplex, eff_aneg_en}, 4'b0110);
    chk(aneg_restart_pulse == 1, "R5", "restart after hw reset", aneg_restart_pulse, 1);
    // pending speed change to 1000, no trigger
    wr(0, 16'h0040);
    chk(eff_speed == 2'b01, "R2", "speed held pending", eff_speed, 1);
    rd(0);
    chk(rd_data == 16'h0040, "R2", "pending readback", rd_data, 16'h0040);
    repeat (3) @(negedge clk);
    chk(eff_speed == 2'b01, "R2", "speed still pending", eff_speed, 1);
    // restart trigger applies, gigabit forces aneg
    wr(0, 16'h0240);
    chk(eff_speed == 2'b10 && eff_aneg_en, "R7", "gig forces aneg", {eff_speed, eff_aneg_en}, 3'b101);
    chk(aneg_restart_pulse && !soft_reset_pulse, "R3", "restart trigger", {aneg_restart_pulse, soft_reset_pulse}, 2'b10);
    @(negedge clk);
    chk(!aneg_restart_pulse, "R5", "pulse one cycle", aneg_restart_pulse, 0);
    rd(0);
    chk(rd_data[9] == 0 && rd_data[15] == 0, "R6", "self clear", rd_data, 16'h0040);
    // software reset applies 10 half, no aneg
    wr(0, 16'h8000);
    chk(eff_speed == 0 && !eff_duplex && !eff_aneg_en && soft_reset_pulse, "R3", "soft reset apply", {eff_speed, eff_duplex, eff_aneg_en, soft_reset_pulse}, 5'b00001);
    // power down, then leave with new speed 100 full
    wr(0, 16'h0800);
    chk(power_down == 1 && !aneg_restart_pulse, "R11", "power down", power_down, 1);
    wr(0, 16'h2100);
    chk(soft_reset_pulse && aneg_restart_pulse, "R4", "leave pd pulses", {soft_reset_pulse, aneg_restart_pulse}, 2'b11);
    chk(eff_speed == 2'b01 && eff_duplex, "R4", "leave pd apply", {eff_speed, eff_duplex}, 3'b011);
    // status reads and ignored write
    rd(1);
    chk(rd_data == 16'h7800, "R8", "status", rd_data, 16'h7800);
    wr(1, 16'hFFFF);
    chk(eff_speed == 2'b01 && !power_down, "R8", "status write ignored", eff_speed, 1);
    rd(1);
    chk(rd_data == 16'h7800, "R8", "status after write", rd_data, 16'h7800);
    rd(7);
    chk(rd_valid && rd_data == 0, "R9", "unimplemented addr", rd_data, 0);
    // collision test
    @(negedge clk); txen = 1;
    tick;
    chk(col_out == 0, "R10", "col off without test", col_out, 0);
    wr(0, 16'h2180);
    tick;
    chk(col_out == 1, "R10", "col follows txen", col_out, 1);
    @(negedge clk); txen = 0;
    repeat (2) @(negedge clk);
    chk(col_out == 1, "R10", "col held between ticks", col_out, 1);
    tick;
    chk(col_out == 0, "R10", "col clears on tick", col_out, 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule